// File: doc/BRIEF.md
# Flash Address Privilege Bitmap Checker

This block decides, for every flash transaction seen by a command decoder, whether the transaction may touch its target address. Flash space is cut into 16 KiB blocks. Two independent bitmaps hold one bit per block, one for reads and one for writes. A set bit grants the access. The decoder presents an address and a direction with a one-cycle strobe. One clock later the block returns an allow or deny verdict.

Software programs the bitmaps through a register window of 512 words. A key byte in the top of the control register chooses whether the window reaches the read table or the write table. A one-way lock bit freezes both tables, so the policy can be set early and then kept unchanged until the next reset. Both tables sit in inferable dual-port RAM. After reset, a sweep writes zero to every word, so no access is granted until software programs the tables.

Top module: `fpc_priv_checker`

## Requirements
- R1: After reset the control register reads 0x5200_0000, the lock register (word offset 1) reads 0, and every lookup is denied because all bitmap bits are 0.
- R2: For each cycle in which `chk_valid` is high, `chk_done` is high exactly one clock later with the verdict on `chk_allow`. Back-to-back strobes give back-to-back results. `chk_done` stays low in every other cycle.
- R3: A lookup uses address bits [27:19] as the word index and bits [18:14] as the bit index within that word. One bit grants a whole 16 KiB block, so every address in the block gets the same verdict.
- R4: A lookup with `chk_is_write`=0 consults only the read table. A lookup with `chk_is_write`=1 consults only the write table. A block can therefore be readable but not writable.
- R5: A write to the control register (word offset 0) selects the read table for the window when bits [31:24] are 0x52, and the write table when they are 0x57. Any other top byte leaves the selection unchanged. Bits [23:0] are stored and read back as written. Bits [31:24] read back as 0x52 or 0x57 to show the current selection.
- R6: Register word offsets 512 to 1023 (`reg_addr[9]`=1) form the window onto word `reg_addr[8:0]` of the selected table. A read returns its data on `reg_rdata` with `reg_rvalid` one clock after `reg_rd_en`.
- R7: Writing 1 to bit 0 of the lock register sets the lock. The lock cannot be cleared except by reset. While it is set, window writes change neither table. Lookups keep using the stored tables.
- R8: Any lookup address at or above 256 MiB (any of bits [31:28] set) is denied, whatever the tables hold.
- R9: For the first 512 cycles after reset the tables are being cleared. During that time lookups are denied and window writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one clock after reg_rd_en |
| chk_valid | input | 1 | Lookup request strobe |
| chk_addr | input | 32 | Flash byte address of the transaction |
| chk_is_write | input | 1 | 1 = write transaction, 0 = read transaction |
| chk_done | output | 1 | Verdict valid, one clock after chk_valid |
| chk_allow | output | 1 | 1 = access granted, valid with chk_done |

## Verification
A corrupted bitmap word or a wrong word/bit split appears on `chk_allow` in the very next cycle after a lookup of an affected block. Window readback exposes the same fault one cycle after a read. A selection register that steers writes to the wrong table only shows when the other direction is looked up, so the bench pairs every table write with lookups in both directions and a readback after switching tables. A lock that leaks shows only after a later window write, so the bench follows each locked write with a readback of the same word.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int NTBL = 2;

  typedef enum logic {
    TBL_RD = 1'b0,
    TBL_WR = 1'b1
  } tbl_sel_e;

  localparam logic [7:0] KEY_RD = 8'h52;
  localparam logic [7:0] KEY_WR = 8'h57;

  // what a pending register read returns
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_HOLD = 2'd1,
    RK_WIN  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/fpc_bitmap_ram.sv
// One privilege table: port A for the register window / clear sweep,
// port B read-only for lookups. Both reads are synchronous.
module fpc_bitmap_ram #(
  parameter int WORDS  = 512,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [WORD_W-1:0] b_rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/fpc_ctrl_regs.sv
// Control/lock registers, window decode, table write steering and the
// post-reset clear sweep.
module fpc_ctrl_regs
  import fpc_pkg::*;
#(
  parameter int WORDS  = 512,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int RA_W  = AW + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  output logic                        reg_rvalid,
  input  logic [NTBL-1:0][WORD_W-1:0] win_q,
  output logic [NTBL-1:0]             tbl_we,
  output logic [AW-1:0]               tbl_addr,
  output logic [WORD_W-1:0]           tbl_wdata,
  output logic                        clearing
);
  localparam int LO_W = WORD_W - 8;

  logic            is_win, is_ctrl, is_lock;
  logic [LO_W-1:0] ctrl_lo_q;
  tbl_sel_e        sel_q, rsel_q;
  logic            lock_q;
  logic            clr_q;
  logic [AW-1:0]   clr_cnt_q;
  rd_kind_e        kind_q;
  logic [WORD_W-1:0] hold_q;

  assign is_win  = reg_addr[RA_W-1];
  assign is_ctrl = !is_win && (reg_addr[RA_W-2:0] == '0);
  assign is_lock = !is_win && (reg_addr[RA_W-2:0] == (RA_W-1)'(1));

  // control and lock registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_lo_q <= '0;
      sel_q     <= TBL_RD;
      lock_q    <= 1'b0;
    end else if (reg_wr_en) begin
      if (is_ctrl) begin
        ctrl_lo_q <= reg_wdata[LO_W-1:0];
        if (reg_wdata[WORD_W-1 -: 8] == KEY_RD)      sel_q <= TBL_RD;
        else if (reg_wdata[WORD_W-1 -: 8] == KEY_WR) sel_q <= TBL_WR;
      end
      if (is_lock && reg_wdata[0]) lock_q <= 1'b1;
    end
  end

  // clear sweep: one word per cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q     <= 1'b1;
      clr_cnt_q <= '0;
    end else if (clr_q) begin
      clr_cnt_q <= clr_cnt_q + 1'b1;
      if (clr_cnt_q == AW'(WORDS - 1)) clr_q <= 1'b0;
    end
  end

  assign clearing  = clr_q;
  assign tbl_addr  = clr_q ? clr_cnt_q : reg_addr[AW-1:0];
  assign tbl_wdata = clr_q ? '0 : reg_wdata;

  always_comb begin
    for (int t = 0; t < NTBL; t++) begin
      tbl_we[t] = clr_q ||
                  (reg_wr_en && is_win && !lock_q && (int'(sel_q) == t));
    end
  end

  // register read path, one cycle latency
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      kind_q     <= RK_NONE;
      rsel_q     <= TBL_RD;
      hold_q     <= '0;
    end else begin
      reg_rvalid <= reg_rd_en;
      rsel_q     <= sel_q;
      if (is_win && !clr_q)   kind_q <= RK_WIN;
      else if (is_ctrl || is_lock) kind_q <= RK_HOLD;
      else                    kind_q <= RK_NONE;
      if (is_ctrl)      hold_q <= {(sel_q == TBL_WR) ? KEY_WR : KEY_RD, ctrl_lo_q};
      else if (is_lock) hold_q <= {{(WORD_W-1){1'b0}}, lock_q};
      else              hold_q <= '0;
    end
  end

  always_comb begin
    case (kind_q)
      RK_WIN:  reg_rdata = win_q[rsel_q];
      RK_HOLD: reg_rdata = hold_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R7
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !clr_q) |-> (tbl_we == '0)); // R7
  AST_ONE_TABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !clr_q |-> $onehot0(tbl_we)); // R4
  AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rvalid); // R6
endmodule

// File: rtl/fpc_lookup.sv
// Splits the transaction address, drives the lookup port of both tables
// and forms the registered verdict.
module fpc_lookup
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 14,
  parameter int WORDS     = 512,
  parameter int WORD_W    = 32,
  localparam int AW       = $clog2(WORDS),
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int TOP      = BLK_SHIFT + BIT_W + AW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        chk_valid,
  input  logic [ADDR_W-1:0]           chk_addr,
  input  logic                        chk_is_write,
  input  logic                        clearing,
  output logic [AW-1:0]               look_addr,
  input  logic [NTBL-1:0][WORD_W-1:0] look_q,
  output logic                        chk_done,
  output logic                        chk_allow
);
  logic             in_range;
  logic             done_q, ok_q;
  tbl_sel_e         dir_q;
  logic [BIT_W-1:0] bit_q;
  logic [WORD_W-1:0] word;
  logic             unused_low;

  assign unused_low = ^chk_addr[BLK_SHIFT-1:0];
  assign in_range   = (chk_addr[ADDR_W-1:TOP] == '0);
  assign look_addr  = chk_addr[BLK_SHIFT+BIT_W +: AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      dir_q  <= TBL_RD;
      bit_q  <= '0;
    end else begin
      done_q <= chk_valid;
      ok_q   <= chk_valid && in_range && !clearing;
      dir_q  <= chk_is_write ? TBL_WR : TBL_RD;
      bit_q  <= chk_addr[BLK_SHIFT +: BIT_W];
    end
  end

  assign word      = look_q[dir_q];
  assign chk_done  = done_q;
  assign chk_allow = done_q && ok_q && word[bit_q];

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_done); // R2
  AST_OUT_OF_RANGE_DENY: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_addr[ADDR_W-1:TOP] != '0) |=> !chk_allow); // R8
  AST_CLEAR_DENY: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && clearing) |=> !chk_allow); // R9
endmodule

// File: rtl/fpc_priv_checker.sv
module fpc_priv_checker
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 14,
  parameter int WORDS     = 512,
  parameter int WORD_W    = 32,
  localparam int AW       = $clog2(WORDS),
  localparam int RA_W     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_is_write,
  output logic              chk_done,
  output logic              chk_allow
);
  logic [NTBL-1:0]             tbl_we;
  logic [AW-1:0]               tbl_addr, look_addr;
  logic [WORD_W-1:0]           tbl_wdata;
  logic [NTBL-1:0][WORD_W-1:0] win_q, look_q;
  logic                        clearing;

  fpc_ctrl_regs #(.WORDS(WORDS), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .win_q(win_q), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .clearing(clearing)
  );

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    fpc_bitmap_ram #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ram (
      .clk(clk),
      .a_we(tbl_we[t]), .a_addr(tbl_addr), .a_wdata(tbl_wdata),
      .a_rdata(win_q[t]),
      .b_addr(look_addr), .b_rdata(look_q[t])
    );
  end

  fpc_lookup #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .WORDS(WORDS),
               .WORD_W(WORD_W)) u_look (
    .clk(clk), .rst(rst),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_is_write(chk_is_write),
    .clearing(clearing), .look_addr(look_addr), .look_q(look_q),
    .chk_done(chk_done), .chk_allow(chk_allow)
  );
endmodule

// File: tb/tb_fpc_priv_checker.sv
module tb_fpc_priv_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        chk_valid = 1'b0, chk_is_write = 1'b0;
  logic [31:0] chk_addr = '0;
  logic        chk_done, chk_allow;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // scoreboard: kind (0 lookup, 1 register read), value, issue cycle, tag
  bit          q_kind[$];
  logic [31:0] q_val[$];
  int          q_cyc[$];
  string       q_tag[$];

  localparam logic [9:0] A_CTRL = 10'd0, A_LOCK = 10'd1, A_WIN = 10'h200;

  fpc_priv_checker dut (.*);

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(bit k, logic [31:0] v, string tag);
    q_kind.push_back(k); q_val.push_back(v); q_cyc.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic pop_check(bit k, logic [31:0] act);
    checks++;
    if (q_kind.size() == 0) begin
      fail_line(k ? "R6" : "R2", "unexpected result", act, 0);
    end else begin
      bit ek = q_kind.pop_front();
      logic [31:0] ev = q_val.pop_front();
      int ec = q_cyc.pop_front();
      string tg = q_tag.pop_front();
      if (ek != k) fail_line(tg, "result kind", 32'(k), 32'(ek));
      else if (cyc != ec + 1) fail_line(tg, "latency", cyc - ec, 1);
      else if (act != ev) fail_line(tg, "value", act, ev);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (chk_done)   pop_check(1'b0, {31'b0, chk_allow});
      if (reg_rvalid) pop_check(1'b1, reg_rdata);
    end
  end

  task automatic reg_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic reg_read(logic [9:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_rd_en = 1; reg_addr = a; push(1'b1, exp, tag);
    @(negedge clk); reg_rd_en = 0;
  endtask

  task automatic lookup(logic [31:0] a, bit w, bit exp, string tag);
    @(negedge clk); chk_valid = 1; chk_addr = a; chk_is_write = w; push(1'b0, {31'b0, exp}, tag);
    @(negedge clk); chk_valid = 0;
  endtask

  task automatic lookup_pair(logic [31:0] a0, bit e0, logic [31:0] a1, bit e1, string tag);
    @(negedge clk); chk_valid = 1; chk_addr = a0; chk_is_write = 0; push(1'b0, {31'b0, e0}, tag);
    @(negedge clk); chk_addr = a1; push(1'b0, {31'b0, e1}, tag);
    @(negedge clk); chk_valid = 0;
  endtask

  task automatic finish_run();
    repeat (4) @(negedge clk);
    checks++;
    if (q_kind.size() != 0) fail_line("R2", "missing results", q_kind.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R9: clear in progress, write to word 0 dropped, lookup denied
    reg_write(A_WIN | 10'd0, 32'hFFFF_FFFF);
    lookup(32'h0000_0000, 0, 0, "R9");
    repeat (600) @(negedge clk);
    reg_read(A_WIN | 10'd0, 32'h0, "R9");
    // R1 reset state
    reg_read(A_CTRL, 32'h5200_0000, "R1");
    reg_read(A_LOCK, 32'h0, "R1");
    lookup(32'h0000_0000, 0, 0, "R1");
    lookup(32'h0000_0000, 1, 0, "R1");
    // R3 word 3 bit 5 in read table
    reg_write(A_CTRL, 32'h5200_ABCD);
    reg_write(A_WIN | 10'd3, 32'h0000_0020);
    lookup(32'h0019_4000, 0, 1, "R3");
    lookup(32'h0019_7FFF, 0, 1, "R3");
    lookup(32'h0019_8000, 0, 0, "R3");
    lookup(32'h0019_3FFF, 0, 0, "R3");
    lookup(32'h0019_4000, 1, 0, "R4");
    // R5/R4 write table word 3 bit 6
    reg_write(A_CTRL, 32'h5700_0123);
    reg_read(A_CTRL, 32'h5700_0123, "R5");
    reg_write(A_WIN | 10'd3, 32'h0000_0040);
    reg_read(A_WIN | 10'd3, 32'h0000_0040, "R6");
    lookup(32'h0019_8000, 1, 1, "R4");
    lookup(32'h0019_8000, 0, 0, "R4");
    lookup(32'h0019_4000, 1, 0, "R4");
    // R5 unknown key keeps selection, low bits stored
    reg_write(A_CTRL, 32'h1100_00FF);
    reg_read(A_CTRL, 32'h5700_00FF, "R5");
    reg_read(A_WIN | 10'd3, 32'h0000_0040, "R5");
    reg_write(A_CTRL, 32'h5200_0000);
    reg_read(A_WIN | 10'd3, 32'h0000_0020, "R6");
    // top of space and R8 range
    reg_write(A_WIN | 10'd511, 32'h8000_0000);
    lookup(32'h0FFF_C000, 0, 1, "R3");
    lookup(32'h0FFF_C000, 1, 0, "R4");
    lookup(32'h1FFF_C000, 0, 0, "R8");
    lookup(32'hFFFF_C000, 0, 0, "R8");
    // R2 back-to-back
    lookup_pair(32'h0019_4000, 1, 32'h0019_8000, 0, "R2");
    // R7 lock
    reg_write(A_LOCK, 32'h1);
    reg_read(A_LOCK, 32'h1, "R7");
    reg_write(A_WIN | 10'd3, 32'h0);
    reg_read(A_WIN | 10'd3, 32'h0000_0020, "R7");
    lookup(32'h0019_4000, 0, 1, "R7");
    reg_write(A_LOCK, 32'h0);
    reg_read(A_LOCK, 32'h1, "R7");
    reg_write(A_CTRL, 32'h5700_0000);
    reg_write(A_WIN | 10'd3, 32'h0);
    reg_read(A_WIN | 10'd3, 32'h0000_0040, "R7");
    lookup(32'h0019_8000, 1, 1, "R7");
    finish_run();
  end
endmodule